// File: doc/BRIEF.md
# One-Shot Temperature Conversion Sequencer

This block sequences a single temperature reading from an on-chip converter. It divides the system clock (up to 80 MHz) down to a converter clock of at most 1 MHz and counts a fixed number of converter cycles after each clear or reset. On the last of those cycles it stores the converter's 8-bit sample and raises a done flag. The stored reading and the flag then stay fixed until the next clear or reset. A second reading only ever starts with a new clear or reset.

An enable input can pause the sequence. While enable is low the converter clock is stopped, conversion makes no progress, and both outputs keep their values. When the block is built without an enable input, the conversion logic is always running. Clear is asynchronous and forces the outputs to a fixed preset code at once. Its release is taken through a two-stage synchroniser clocked by converter ticks, so counting always begins from zero.

The sample bus is a plain level input and the result is a held register. There is no valid/ready handshake, because the block makes exactly one reading per clear and never has a second item to stall. Done acts as a sticky valid with no back-pressure. The divide ratio is checked while the design is elaborated: a ratio that is odd, or that would give more than 1 MHz from an 80 MHz clock, stops elaboration.

Top module: `tsense_oneshot`

## Requirements
- R1: While `rst_n` is low or `clr` is high, `done` is 0 and `result` is 8'hD5. Both take these values immediately, without waiting for a clock edge.
- R2: With enable high, `conv_clk` has a period of DIV system cycles and is high for DIV/2 of them. Its first rising edge falls on the DIV-th system edge after clear is released. Within the first 10*DIV edges it rises exactly 10 times.
- R3: With enable held high, `done` is still 0 after system edge 10*DIV-1 counted from clear release. It is 1 after edge 10*DIV, which is the tenth converter rising edge.
- R4: `result` takes the value of `smp_data` on the same edge that raises `done`.
- R5: Once `done` is 1, `done` and `result` hold their values until the next clear or reset, whatever `smp_data` does.
- R6: While enable is low, `conv_clk` is 0, `done` and `result` do not change, and the divider phase restarts. Conversion resumes when enable returns. Every full converter period completed before the pause still counts, and the next converter rising edge comes DIV edges after enable rises again.
- R7: Toggling enable after `done` has risen does not start a new measurement.
- R8: A clear in the middle of a conversion discards the progress made so far. The next `done` comes a full 10*DIV edges after that clear is released.
- R9: With parameter HAS_ENABLE = 0, the `en` input is ignored and conversion runs as if enable were high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, up to 80 MHz |
| rst_n | input | 1 | Asynchronous device reset, active low |
| en | input | 1 | Enable for the converter clock and the sequence; ignored when HAS_ENABLE = 0 |
| clr | input | 1 | Asynchronous clear, active high; starts a new measurement when released |
| smp_data | input | 8 | Sample bus from the converter |
| conv_clk | output | 1 | Divided converter clock |
| result | output | 8 | Held temperature code; preset 8'hD5 |
| done | output | 1 | Measurement complete; result is valid while this is high |

## Verification
The preset values appear without any clock edge, so the bench checks them one time unit after driving clear or reset. All other timing is counted in system edges from the clear release, which the bench makes on a falling edge. The first converter rise is due at edge DIV, and `done` together with the captured sample is due at edge 10*DIV. `done` is checked low after edge 10*DIV-1 and high after edge 10*DIV. When enable is paused after k edges, the bench computes the remaining wait as (10 - k/DIV)*DIV edges after enable returns, and every sample is taken on the falling edge after the counted rising edge.

// File: rtl/tsense_pkg.sv
package tsense_pkg;
  localparam int unsigned CODE_W      = 8;
  localparam logic [7:0]  PRESET_CODE = 8'hD5;
  localparam int unsigned SYS_HZ_MAX  = 80_000_000;
  localparam int unsigned CONV_HZ_MAX = 1_000_000;
  localparam int unsigned MIN_DIV     = SYS_HZ_MAX / CONV_HZ_MAX;
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/tsense_clkdiv.sv
module tsense_clkdiv #(
  parameter int unsigned DIV = 80
) (
  input  logic clk,
  input  logic arst_n,
  input  logic run,
  output logic conv_clk,
  output logic tick
);
  localparam int unsigned HALF = DIV / 2;
  localparam int unsigned CW   = $clog2(DIV);
  localparam logic [CW-1:0] LAST     = CW'(DIV - 1);
  localparam logic [CW-1:0] FALL_AT  = CW'(HALF - 1);

  logic [CW-1:0] phase_q;
  logic          clk_q;

  // tick marks the system edge on which the converter clock rises
  assign tick     = run && (phase_q == LAST);
  assign conv_clk = clk_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      phase_q <= '0;
      clk_q   <= 1'b0;
    end else if (!run) begin
      phase_q <= '0;
      clk_q   <= 1'b0;
    end else if (phase_q == LAST) begin
      phase_q <= '0;
      clk_q   <= 1'b1;
    end else begin
      phase_q <= phase_q + 1'b1;
      if (phase_q == FALL_AT) clk_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tsense_arm.sv
module tsense_arm #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic tick,
  output logic armed
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)   sync_q <= '0;
    else if (tick) sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign armed = sync_q[STAGES-1];
endmodule

// File: rtl/tsense_capture.sv
module tsense_capture
  import tsense_pkg::*;
#(
  parameter int unsigned CONV_TICKS  = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  arst_n,
  input  logic  tick,
  input  logic  armed,
  input  code_t sample,
  output code_t code,
  output logic  done
);
  localparam int unsigned LIMIT = CONV_TICKS - SYNC_STAGES;
  localparam int unsigned CW    = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  code_t         code_q;
  logic          done_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q  <= '0;
      code_q <= PRESET_CODE;
      done_q <= 1'b0;
    end else if (tick && armed && !done_q) begin
      if (cnt_q == LAST_CNT) begin
        done_q <= 1'b1;
        code_q <= sample;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign code = code_q;
  assign done = done_q;
endmodule

// File: rtl/tsense_oneshot.sv
module tsense_oneshot
  import tsense_pkg::*;
#(
  parameter int unsigned DIV         = 80,
  parameter int unsigned CONV_TICKS  = 10,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          HAS_ENABLE  = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       clr,
  input  logic [7:0] smp_data,
  output logic       conv_clk,
  output logic [7:0] result,
  output logic       done
);
  if (DIV < MIN_DIV || (DIV % 2) != 0) begin : g_bad_div
    $error("tsense_oneshot: DIV must be even and at least %0d", MIN_DIV);
  end
  if (SYNC_STAGES < 2 || CONV_TICKS <= SYNC_STAGES) begin : g_bad_seq
    $error("tsense_oneshot: need SYNC_STAGES >= 2 and CONV_TICKS > SYNC_STAGES");
  end

  logic run;
  logic tick;
  logic armed;
  logic arst_n;

  assign arst_n = rst_n & ~clr;

  if (HAS_ENABLE) begin : g_en
    assign run = en;
  end else begin : g_no_en
    assign run = 1'b1;
  end

  tsense_clkdiv #(.DIV(DIV)) u_div (
    .clk      (clk),
    .arst_n   (arst_n),
    .run      (run),
    .conv_clk (conv_clk),
    .tick     (tick)
  );

  tsense_arm #(.STAGES(SYNC_STAGES)) u_arm (
    .clk    (clk),
    .arst_n (arst_n),
    .tick   (tick),
    .armed  (armed)
  );

  tsense_capture #(
    .CONV_TICKS  (CONV_TICKS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_cap (
    .clk    (clk),
    .arst_n (arst_n),
    .tick   (tick),
    .armed  (armed),
    .sample (smp_data),
    .code   (result),
    .done   (done)
  );
endmodule

// File: rtl/tsense_oneshot_chk.sv
module tsense_oneshot_chk #(
  parameter bit HAS_ENABLE = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       clr,
  input logic       en,
  input logic       conv_clk,
  input logic [7:0] smp_data,
  input logic [7:0] result,
  input logic       done
);
  logic en_eff;
  assign en_eff = HAS_ENABLE ? en : 1'b1;

  // R1: preset values while reset or clear is applied
  always @(posedge clk) begin
    if (!rst_n || clr) begin
      p_preset_r1: assert (result == 8'hD5 && !done)
        else $error("preset violated");
    end
  end

  // R5: done is sticky until clear
  p_done_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n || clr)
    done |=> done);

  // R5: result held once done
  p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n || clr)
    done |=> $stable(result));

  // R6: outputs frozen while enable is low
  p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n || clr)
    !en_eff |=> ($stable(done) && $stable(result)));

  // R6: converter clock stopped low while enable is low
  p_clk_stop_r6: assert property (@(posedge clk) disable iff (!rst_n || clr)
    !en_eff |=> !conv_clk);

  // R3: done only rises together with a converter clock rise
  p_done_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n || clr)
    $rose(done) |-> $rose(conv_clk));

  // R4: captured code equals the sample present at the completing edge
  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n || clr)
    $rose(done) |-> (result == $past(smp_data)));
endmodule

bind tsense_oneshot tsense_oneshot_chk #(.HAS_ENABLE(HAS_ENABLE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clr      (clr),
  .en       (en),
  .conv_clk (conv_clk),
  .smp_data (smp_data),
  .result   (result),
  .done     (done)
);

// File: tb/tsense_oneshot_tb.sv
module tsense_oneshot_tb;
  localparam int DIV   = 80;
  localparam int HALF  = DIV / 2;
  localparam int TICKS = 10;
  localparam int WDOG  = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       en = 1'b1;
  logic       en_off = 1'b0;
  logic       clr = 1'b0;
  logic [7:0] smp = 8'h00;
  logic       cc, cc2, dn, dn2;
  logic [7:0] res, res2;

  int nchk = 0;
  int nerr = 0;
  int rises = 0;
  int highs = 0;
  logic prev_cc = 1'b0;

  always #10 clk = ~clk;

  tsense_oneshot #(.DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .smp_data(smp),
    .conv_clk(cc), .result(res), .done(dn)
  );

  tsense_oneshot #(.DIV(DIV), .HAS_ENABLE(1'b0)) u_dut_noen (
    .clk(clk), .rst_n(rst_n), .en(en_off), .clr(clr), .smp_data(smp),
    .conv_clk(cc2), .result(res2), .done(dn2)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // wait n rising edges, sampling conv_clk on each following falling edge
  task automatic wait_edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (cc && !prev_cc) rises++;
      if (cc) highs++;
      prev_cc = cc;
    end
  endtask

  function automatic int remain_after(input int k);
    return (TICKS - k / DIV) * DIV;
  endfunction

  task automatic do_clear();
    @(negedge clk);
    clr = 1'b1;
    #1;
    chk(res == 8'hD5, "R1 clear result", res, 8'hD5);
    chk(dn == 1'b0, "R1 clear done", dn, 0);
    repeat (DIV + 2) @(negedge clk);
    clr = 1'b0;
    prev_cc = 1'b0;
    rises = 0;
    highs = 0;
  endtask

  task automatic run_conv(input logic [7:0] s, input int pause_at, input int pause_len);
    int rem;
    smp = s;
    do_clear();
    if (pause_at > 0) begin
      wait_edges(pause_at);
      en = 1'b0;
      wait_edges(pause_len);
      chk(dn == 1'b0, "R6 frozen done", dn, 0);
      chk(res == 8'hD5, "R6 frozen result", res, 8'hD5);
      chk(cc == 1'b0, "R6 clock stopped", cc, 0);
      en = 1'b1;
      rem = remain_after(pause_at);
    end else begin
      rem = TICKS * DIV;
    end
    wait_edges(rem - 1);
    chk(dn == 1'b0, "R3 not yet done", dn, 0);
    if (pause_at == 0) chk(dn2 == 1'b0, "R9 noen not yet done", dn2, 0);
    wait_edges(1);
    chk(dn == 1'b1, "R3 done on time", dn, 1);
    chk(res == s, "R4 captured sample", res, s);
    chk(dn2 == 1'b1, "R9 noen done", dn2, 1);
    chk(res2 == s, "R9 noen result", res2, s);
    if (pause_at == 0) begin
      chk(rises == TICKS, "R2 converter rises", rises, TICKS);
      chk(highs == (TICKS - 1) * HALF + 1, "R2 high time", highs, (TICKS - 1) * HALF + 1);
    end
    // R5: sample changes do not reach the result
    smp = ~s;
    wait_edges(3 * DIV);
    chk(dn == 1'b1 && res == s, "R5 hold", res, s);
  endtask

  initial begin : watchdog
    repeat (WDOG) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin : main
    logic [7:0] s;
    void'($urandom(32'd20240611));
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(res == 8'hD5 && dn == 1'b0, "R1 reset preset", res, 8'hD5);
    chk(cc == 1'b0, "R1 reset clock low", cc, 0);
    rst_n = 1'b1;

    // directed: full run, then enable toggle after done (R7)
    run_conv(8'h3C, 0, 0);
    en = 1'b0;
    wait_edges(2 * DIV);
    en = 1'b1;
    wait_edges(12 * DIV);
    chk(dn == 1'b1 && res == 8'h3C, "R7 no re-arm", res, 8'h3C);

    // directed: pause just before completion, and right at a period edge
    run_conv(8'hFF, TICKS * DIV - 1, 37);
    run_conv(8'h00, 3 * DIV, 5);

    // R8: clear in mid conversion restarts the count
    smp = 8'h77;
    do_clear();
    wait_edges(5 * DIV + 3);
    chk(dn == 1'b0, "R8 mid conversion", dn, 0);
    run_conv(8'h5A, 0, 0);

    // random runs
    for (int r = 0; r < 6; r++) begin
      s = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 1) == 1)
        run_conv(s, $urandom_range(1, TICKS * DIV - 1), $urandom_range(1, 3 * DIV));
      else
        run_conv(s, 0, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule